// File: doc/BRIEF.md
# Unaligned Fetch Window Splitter

This block sits between an instruction fetch requester and a memory that is read only in whole 16-byte segments. The requester asks for a 16-byte window of instruction bytes that may begin at any byte address. The block rounds the address down to a segment boundary and reads that segment. If the window spills into the following segment, it reads that segment in the very next cycle. It then assembles the requested bytes into one 128-bit window.

The memory port returns data exactly one cycle after each strobe. While a window is being built, the request side is held off through a valid/ready handshake. The finished window leaves on a one-cycle valid pulse. The pulse carries a flag that tells performance counters whether the window needed two reads.

Top module: `fetch_window_splitter`

## Requirements
- R1: Every memory strobe carries an address whose low 4 bits are zero. The first strobe for a request carries the request address rounded down to a multiple of 16.
- R2: A request whose low 4 address bits are zero causes exactly one memory strobe, and its window reports win_split = 0.
- R3: A request whose low 4 address bits are nonzero causes a second strobe in the cycle right after the first. The second strobe's address is the first address plus 16.
- R4: When the first segment has index 3 within its 64-byte line (address bits [5:4] = 3), the second strobe goes to index 0 of the next line. The address wraps modulo 2^ADDR_W at the top of the address space.
- R5: Byte i of win_data, at bits [8i+7:8i], equals the memory byte at (req_addr + i). Inside each segment read, memory byte k sits at mem_rd_data bits [8k+7:8k], and that data arrives the cycle after its strobe.
- R6: req_ready is low from the edge that accepts a request until the window is delivered. For a request accepted at edge N, win_valid is high after edge N+1 when one read is needed, and after edge N+2 when two are needed.
- R7: Each accepted request yields exactly one win_valid pulse, one cycle wide. win_split is 1 with that pulse exactly when two strobes were issued.
- R8: A synchronous active-high reset returns the block to idle with req_ready high and win_valid low. A request that was in progress during reset never produces a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Requester has a window request |
| req_ready | output | 1 | Block can accept a request (low means stall) |
| req_addr | input | ADDR_W | Byte address of the first window byte |
| mem_rd_en | output | 1 | Segment read strobe |
| mem_rd_addr | output | ADDR_W | Segment-aligned read address |
| mem_rd_data | input | 8*SEG_BYTES | Segment data, one cycle after the strobe |
| win_valid | output | 1 | One-cycle pulse: window ready |
| win_data | output | 8*SEG_BYTES | Assembled window, byte 0 in the low bits |
| win_split | output | 1 | Window needed two segment reads |

## Verification
Start offsets 0, 1, 8 and 15 are applied.
- Offset 0 separates the single-read path from the two-read path.
- Offsets 1 and 15 hit the extremes of the byte rotation, where an off-by-one in the merge shows up.
- Offset 8 mirrors the half-and-half case.

Segment index 3 and the top of the address space exercise the carry into the next line and the address wrap. A run of pseudo-random addresses is also issued back to back, which checks that a new request is accepted in the cycle a window leaves. A reset is asserted while a split is in progress and must suppress that window.

// File: rtl/fws_pkg.sv
package fws_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_FIRST  = 2'd1,
      SQ_SECOND = 2'd2
   } seq_state_e;
endpackage

// File: rtl/fws_align.sv
module fws_align #(
   parameter int ADDR_W    = 32,
   parameter int SEG_BYTES = 16,
   localparam int OFF_W    = $clog2(SEG_BYTES)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] seg_addr,
   output logic [ADDR_W-1:0] next_seg_addr,
   output logic [OFF_W-1:0]  offset,
   output logic              needs_split
);
   assign offset        = addr[OFF_W-1:0];
   assign seg_addr      = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign next_seg_addr = seg_addr + ADDR_W'(SEG_BYTES);
   assign needs_split   = |offset;
endmodule

// File: rtl/fws_merge.sv
module fws_merge #(
   parameter int SEG_BYTES   = 16,
   parameter bit USE_SHIFTER = 1'b0,
   localparam int OFF_W      = $clog2(SEG_BYTES),
   localparam int SEG_W      = SEG_BYTES * 8
) (
   input  logic [SEG_W-1:0] lo,
   input  logic [SEG_W-1:0] hi,
   input  logic [OFF_W-1:0] off,
   output logic [SEG_W-1:0] win
);
   logic [2*SEG_W-1:0] cat;
   assign cat = {hi, lo};

   generate
      if (USE_SHIFTER) begin : g_shift
         logic [2*SEG_W-1:0] shifted;
         assign shifted = cat >> {off, 3'b000};
         assign win     = shifted[SEG_W-1:0];
      end else begin : g_bytemux
         for (genvar gi = 0; gi < SEG_BYTES; gi++) begin : g_byte
            logic [OFF_W:0] idx;
            assign idx = (OFF_W+1)'(off) + (OFF_W+1)'(gi);
            assign win[gi*8 +: 8] = cat[{idx, 3'b000} +: 8];
         end
      end
   endgenerate
endmodule

// File: rtl/fws_seq.sv
module fws_seq
   import fws_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req_valid,
   input  logic needs_split,
   output logic req_ready,
   output logic accept,
   output logic issue_second,
   output logic load_out,
   output logic split_q
);
   seq_state_e state;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= SQ_IDLE;
         split_q <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: if (req_valid) begin
               state   <= SQ_FIRST;
               split_q <= needs_split;
            end
            SQ_FIRST:  state <= split_q ? SQ_SECOND : SQ_IDLE;
            SQ_SECOND: state <= SQ_IDLE;
            default:   state <= SQ_IDLE;
         endcase
      end
   end

   assign req_ready    = (state == SQ_IDLE);
   assign accept       = req_ready && req_valid;
   assign issue_second = (state == SQ_FIRST) && split_q;
   assign load_out     = ((state == SQ_FIRST) && !split_q) || (state == SQ_SECOND);

   // R7
   one_load_chk: assert property (@(posedge clk) disable iff (rst)
      load_out |=> !load_out);
endmodule

// File: rtl/fetch_window_splitter.sv
module fetch_window_splitter #(
   parameter int ADDR_W      = 32,
   parameter int SEG_BYTES   = 16,
   parameter int LINE_BYTES  = 64,
   parameter bit USE_SHIFTER = 1'b0,
   localparam int SEG_W      = SEG_BYTES * 8,
   localparam int OFF_W      = $clog2(SEG_BYTES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [SEG_W-1:0]  mem_rd_data,
   output logic              win_valid,
   output logic [SEG_W-1:0]  win_data,
   output logic              win_split
);
   localparam int SEGS_PER_LINE = LINE_BYTES / SEG_BYTES;

   generate
      if ((1 << OFF_W) != SEG_BYTES) begin : g_bad_seg
         $error("SEG_BYTES must be a power of two");
      end
      if (SEGS_PER_LINE < 1 || SEGS_PER_LINE * SEG_BYTES != LINE_BYTES) begin : g_bad_line
         $error("LINE_BYTES must be a whole multiple of SEG_BYTES");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("ADDR_W too narrow for segment offset");
      end
   endgenerate

   logic [ADDR_W-1:0] al_seg, al_next;
   logic [OFF_W-1:0]  al_off;
   logic              al_split;
   logic              accept, issue_second, load_out, split_q;
   logic [OFF_W-1:0]  off_q;
   logic [ADDR_W-1:0] next_q;
   logic [SEG_W-1:0]  low_q, merged, merge_lo;
   logic              win_valid_q, win_split_q;
   logic [SEG_W-1:0]  win_data_q;

   fws_align #(.ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) u_align (
      .addr(req_addr), .seg_addr(al_seg), .next_seg_addr(al_next),
      .offset(al_off), .needs_split(al_split));

   fws_seq u_seq (
      .clk(clk), .rst(rst), .req_valid(req_valid), .needs_split(al_split),
      .req_ready(req_ready), .accept(accept), .issue_second(issue_second),
      .load_out(load_out), .split_q(split_q));

   assign merge_lo = split_q ? low_q : mem_rd_data;

   fws_merge #(.SEG_BYTES(SEG_BYTES), .USE_SHIFTER(USE_SHIFTER)) u_merge (
      .lo(merge_lo), .hi(mem_rd_data), .off(off_q), .win(merged));

   assign mem_rd_en   = accept || issue_second;
   assign mem_rd_addr = issue_second ? next_q : al_seg;

   always_ff @(posedge clk) begin
      if (rst) begin
         win_valid_q <= 1'b0;
         win_split_q <= 1'b0;
         off_q       <= '0;
         next_q      <= '0;
         low_q       <= '0;
         win_data_q  <= '0;
      end else begin
         win_valid_q <= load_out;
         if (accept) begin
            off_q  <= al_off;
            next_q <= al_next;
         end
         if (issue_second) low_q <= mem_rd_data;
         if (load_out) begin
            win_data_q  <= merged;
            win_split_q <= split_q;
         end
      end
   end

   assign win_valid = win_valid_q;
   assign win_data  = win_data_q;
   assign win_split = win_split_q;

   // R1
   seg_align_chk: assert property (@(posedge clk) disable iff (rst)
      mem_rd_en |-> (mem_rd_addr[OFF_W-1:0] == '0));
   // R2
   single_access_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(req_valid && req_ready) && ($past(req_addr[OFF_W-1:0]) == '0)) |-> !mem_rd_en);
   // R3
   back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(req_valid && req_ready) && ($past(req_addr[OFF_W-1:0]) != '0))
      |-> (mem_rd_en && (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(SEG_BYTES))));
   // R6
   stall_chk: assert property (@(posedge clk) disable iff (rst)
      $past(req_valid && req_ready) |-> !req_ready);
   // R7
   pulse_chk: assert property (@(posedge clk) disable iff (rst)
      win_valid |=> !win_valid);
endmodule

// File: tb/fetch_window_splitter_test.sv
`timescale 1ns/1ps
module fetch_window_splitter_test;
   localparam int AW = 32;
   localparam int SB = 16;
   localparam int SW = SB * 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          mem_rd_en;
   logic [AW-1:0] mem_rd_addr;
   logic [SW-1:0] mem_rd_data = '0;
   logic          win_valid;
   logic [SW-1:0] win_data;
   logic          win_split;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit busy   = 1'b0;
   bit done   = 1'b0;

   logic [AW-1:0] q_addr[$];
   int            q_cyc[$];

   int            acc_n = 0;
   logic [AW-1:0] acc_a0 = '0, acc_a1 = '0;

   fetch_window_splitter #(.ADDR_W(AW), .SEG_BYTES(SB)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .win_valid(win_valid), .win_data(win_data),
      .win_split(win_split));

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] memb(input logic [AW-1:0] a);
      return (a[7:0] * 8'd13) ^ a[15:8] ^ (a[23:16] * 8'd3) ^ a[31:24];
   endfunction

   function automatic logic [SW-1:0] seg_of(input logic [AW-1:0] a);
      logic [SW-1:0] d;
      for (int k = 0; k < SB; k++) d[k*8 +: 8] = memb(a + AW'(k));
      return d;
   endfunction

   function automatic logic [SW-1:0] win_of(input logic [AW-1:0] a);
      logic [SW-1:0] d;
      for (int i = 0; i < SB; i++) d[i*8 +: 8] = memb(a + AW'(i));
      return d;
   endfunction

   // memory model, one-cycle read latency
   always @(posedge clk) if (mem_rd_en) mem_rd_data <= seg_of(mem_rd_addr);

   task automatic chk(input bit ok, input string req, input logic [SW-1:0] act,
                      input logic [SW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [AW-1:0] a);
      req_addr  = a;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      busy      = 1'b1;
      q_addr.push_back(a);
      q_cyc.push_back(cyc + ((a[3:0] != 4'd0) ? 2 : 1));
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst) begin
            acc_n = 0;
         end else begin
            if (win_valid) begin
               if (q_addr.size() == 0) begin
                  chk(1'b0, "R8 unexpected window", SW'(win_valid), SW'(0));
               end else begin
                  logic [AW-1:0] a;
                  int            ec;
                  bit            sp;
                  a  = q_addr.pop_front();
                  ec = q_cyc.pop_front();
                  sp = (a[3:0] != 4'd0);
                  busy = 1'b0;
                  chk(win_data == win_of(a), "R5 window bytes", win_data, win_of(a));
                  chk(win_split == sp, "R7 split flag", SW'(win_split), SW'(sp));
                  chk(cyc == ec, "R6 delivery cycle", SW'(cyc), SW'(ec));
                  chk(acc_n == (sp ? 2 : 1), sp ? "R3 strobe count" : "R2 strobe count",
                      SW'(acc_n), SW'(sp ? 2 : 1));
                  chk(acc_a0 == {a[AW-1:4], 4'h0}, "R1 first address",
                      SW'(acc_a0), SW'({a[AW-1:4], 4'h0}));
                  if (sp) begin
                     if (a[5:4] == 2'd3)
                        chk(acc_a1 == {a[AW-1:4], 4'h0} + 32'd16, "R4 line crossing address",
                            SW'(acc_a1), SW'({a[AW-1:4], 4'h0} + 32'd16));
                     else
                        chk(acc_a1 == {a[AW-1:4], 4'h0} + 32'd16, "R3 second address",
                            SW'(acc_a1), SW'({a[AW-1:4], 4'h0} + 32'd16));
                  end
               end
               acc_n = 0;
            end else if (busy) begin
               chk(!req_ready, "R6 stall while pending", SW'(req_ready), SW'(0));
            end
            if (mem_rd_en) begin
               chk(mem_rd_addr[3:0] == 4'd0, "R1 aligned strobe", SW'(mem_rd_addr), SW'(0));
               if (acc_n == 0) acc_a0 = mem_rd_addr;
               else acc_a1 = mem_rd_addr;
               acc_n++;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] lcg;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(req_ready == 1'b1, "R8 ready in reset", SW'(req_ready), SW'(1));
      chk(win_valid == 1'b0, "R8 no window in reset", SW'(win_valid), SW'(0));
      chk(mem_rd_en == 1'b0, "R8 no strobe in reset", SW'(mem_rd_en), SW'(0));
      rst = 1'b0;
      @(negedge clk);

      send(32'h0000_1000);   // R2 aligned
      send(32'h0000_1008);   // R3 middle offset
      send(32'h0000_1001);   // R5 offset 1
      send(32'h0000_100F);   // R5 offset 15
      send(32'h0000_1030);   // R2 aligned, index 3
      send(32'h0000_103C);   // R4 index 3 into next line
      send(32'hFFFF_FFF8);   // R4 wrap of address space
      lcg = 32'h1234_5677;
      for (int n = 0; n < 24; n++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         send(lcg);
      end
      repeat (4) @(negedge clk);

      // R8 reset during a split access
      req_addr  = 32'h0000_2108;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(req_ready == 1'b1, "R8 ready after mid-split reset", SW'(req_ready), SW'(1));
      rst = 1'b0;
      repeat (4) @(negedge clk);
      chk(win_valid == 1'b0, "R8 dropped window stays silent", SW'(win_valid), SW'(0));
      send(32'h0000_2108);
      repeat (6) @(negedge clk);
      chk(q_addr.size() == 0, "R7 every request delivered", SW'(q_addr.size()), SW'(0));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule